// File: doc/BRIEF.md
# Acknowledge Chain Origin Driver

This block sits in the first backplane slot and starts the interrupt acknowledge daisy chain. It watches three active-low bus inputs: the backplane acknowledge line, which is also the first slot's chain input; the address strobe; and the first data strobe. It drives one active-low chain output that feeds the next slot. A falling data strobe starts the chain only while the acknowledge line is low, so ordinary data transfers never start it.

Every input passes through a multi-flop synchronizer. Edges are found on the synchronized copies. Once a qualified edge is seen, a programmable delay counts down before the chain output is pulled low. The output is released as soon as the address strobe is seen high. After that, the output is held high for a programmable recovery time before it may be pulled low again. If the address strobe goes high while the delay is still counting, the pending assertion is dropped.

Top module: `iack_chain_origin`

## Requirements
- R1: `chain_out_n` is 1 (released) while `rst_n` is low and stays 1 while no qualified start has occurred.
- R2: A falling edge of the synchronized `data_strobe_a_n` starts the chain only when the synchronized `bus_ack_n` is 0 at that edge. With `bus_ack_n` at 1, a falling data strobe leaves `chain_out_n` at 1.
- R3: A level is not an edge. `bus_ack_n` falling while `data_strobe_a_n` is already held at 0 leaves `chain_out_n` at 1.
- R4: After a qualified start with the address strobe held low, `chain_out_n` is first seen 0 after exactly SYNC_STAGES+ASSERT_DLY+1 rising clock edges. The count starts with the first edge after the data strobe input changes.
- R5: While `chain_out_n` is 0, the synchronized `addr_strobe_n` at 1 returns it to 1 at the next edge. From the input change, this takes SYNC_STAGES+1 edges, which is never more than RELEASE_MAX.
- R6: If the synchronized `addr_strobe_n` is 1 at any edge during the delay, the pending assertion is cancelled and `chain_out_n` stays 1. This includes the edge on which the delay would expire: cancellation wins.
- R7: After a release, qualified data strobe edges sampled within RECOVER_CYC edges are ignored and not remembered. The output then stays high for at least RECOVER_CYC edges.
- R8: Once the recovery time has passed, a new qualified edge asserts `chain_out_n` again with the R4 latency.
- R9: While `chain_out_n` is 0 and the synchronized `addr_strobe_n` is 0, `chain_out_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ack_n | input | 1 | Backplane acknowledge line, also the first slot's chain input (active low) |
| addr_strobe_n | input | 1 | Address strobe (active low) |
| data_strobe_a_n | input | 1 | First data strobe (active low) |
| chain_out_n | output | 1 | Chain output to the next slot (active low) |

## Verification
Two events can land on the same edge: the assertion delay expiring and a synchronized address strobe seen high. The bench sets this up by raising the address strobe exactly ASSERT_DLY edges after the data strobe falls. It checks that the output never goes low. A neighbouring case raises the strobe one edge later. There the output must go low for exactly one sample and then be released. A further case places a second qualified edge inside the recovery window and checks that it is dropped rather than deferred.

// File: rtl/iackc_pkg.sv
package iackc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_DRIVE = 2'd2,
      ST_HOLD  = 2'd3
   } chain_st_e;

   localparam int unsigned IN_W = 3;
   localparam int unsigned IDX_ACK = 0;
   localparam int unsigned IDX_AS  = 1;
   localparam int unsigned IDX_DSA = 2;
endpackage

// File: rtl/iackc_sync.sv
module iackc_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [WIDTH-1:0] q_r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q_r <= RST_VAL;
               else        q_r <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q_r <= RST_VAL;
               else        q_r <= g_stage[i-1].q_r;
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/iackc_fsm.sv
module iackc_fsm
   import iackc_pkg::*;
#(
   parameter int unsigned ASSERT_DLY  = 4,
   parameter int unsigned RECOVER_CYC = 6,
   parameter int unsigned CNT_W       = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   output logic chain_n_o
);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(ASSERT_DLY);
   localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECOVER_CYC);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   chain_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         out_q <= 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q  <= ST_WAIT;
                  cnt_q <= CNT_ONE;
               end
            end
            ST_WAIT: begin
               if (stop_i) begin
                  st_q <= ST_IDLE;
               end else if (cnt_q == DLY_LAST) begin
                  st_q  <= ST_DRIVE;
                  out_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
            ST_DRIVE: begin
               if (stop_i) begin
                  st_q  <= ST_HOLD;
                  out_q <= 1'b1;
                  cnt_q <= CNT_ONE;
               end
            end
            ST_HOLD: begin
               if (cnt_q == REC_LAST) st_q  <= ST_IDLE;
               else                   cnt_q <= cnt_q + CNT_ONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign chain_n_o = out_q;
endmodule

// File: rtl/iack_chain_origin.sv
module iack_chain_origin
   import iackc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ASSERT_DLY  = 4,
   parameter int unsigned RELEASE_MAX = 8,
   parameter int unsigned RECOVER_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_ack_n,
   input  logic addr_strobe_n,
   input  logic data_strobe_a_n,
   output logic chain_out_n
);
   localparam int unsigned CNT_MAX = (ASSERT_DLY > RECOVER_CYC) ? ASSERT_DLY : RECOVER_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ASSERT_DLY < 1) begin : g_bad_dly
         $error("ASSERT_DLY must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_bad_rec
         $error("RECOVER_CYC must be at least 1");
      end
      if (RELEASE_MAX < SYNC_STAGES + 1) begin : g_bad_rel
         $error("RELEASE_MAX cannot cover the synchronizer plus one register");
      end
   endgenerate

   logic [IN_W-1:0] raw_in, sync_in;
   logic            ack_s, as_s, dsa_s, dsa_d;
   logic            dsa_fall, start, stop;

   assign raw_in[IDX_ACK] = bus_ack_n;
   assign raw_in[IDX_AS]  = addr_strobe_n;
   assign raw_in[IDX_DSA] = data_strobe_a_n;

   iackc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_in)
   );

   assign ack_s = sync_in[IDX_ACK];
   assign as_s  = sync_in[IDX_AS];
   assign dsa_s = sync_in[IDX_DSA];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dsa_d <= 1'b1;
      else        dsa_d <= dsa_s;

   assign dsa_fall = dsa_d & ~dsa_s;
   assign start    = dsa_fall & ~ack_s;
   assign stop     = as_s;

   iackc_fsm #(.ASSERT_DLY(ASSERT_DLY), .RECOVER_CYC(RECOVER_CYC), .CNT_W(CNT_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .stop_i    (stop),
      .chain_n_o (chain_out_n)
   );
endmodule

// File: rtl/iackc_chk.sv
module iackc_chk #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RELEASE_MAX = 8,
   parameter int unsigned RECOVER_CYC = 6
) (
   input logic clk,
   input logic rst_n,
   input logic chain_n,
   input logic as_raw_n,
   input logic as_sync_n
);
   localparam int unsigned REL_W = $clog2(RELEASE_MAX + 2) + 1;
   localparam int unsigned HI_W  = $clog2(RECOVER_CYC + 1) + 1;

   logic [REL_W-1:0] rel_cnt;
   logic [HI_W-1:0]  hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel_cnt <= '0;
      else if (!chain_n && as_raw_n) begin
         if (rel_cnt <= REL_W'(RELEASE_MAX)) rel_cnt <= rel_cnt + 1'b1;
      end else rel_cnt <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= HI_W'(RECOVER_CYC);
      else if (!chain_n) hi_cnt <= '0;
      else if (hi_cnt < HI_W'(RECOVER_CYC)) hi_cnt <= hi_cnt + 1'b1;
   end

   a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_n && !as_sync_n) |=> !chain_n);

   a_r5_release_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!chain_n && as_sync_n) |=> chain_n);

   a_r5_release_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rel_cnt <= REL_W'(RELEASE_MAX));

   a_r6_no_assert_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chain_n) |-> !$past(as_sync_n));

   a_r7_min_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chain_n) |-> (hi_cnt >= HI_W'(RECOVER_CYC)));
endmodule

bind iack_chain_origin iackc_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .RELEASE_MAX (RELEASE_MAX),
   .RECOVER_CYC (RECOVER_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chain_n   (chain_out_n),
   .as_raw_n  (addr_strobe_n),
   .as_sync_n (as_s)
);

// File: tb/sim_iack_chain_origin.sv
module sim_iack_chain_origin;
   localparam int SYNC = 2;
   localparam int DLY  = 4;
   localparam int REL  = 8;
   localparam int REC  = 6;
   localparam int WIN  = 40;
   localparam int LAT  = SYNC + DLY + 1;

   typedef struct packed {
      logic       ack;
      logic [7:0] as_off;
      logic       exp_low;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{ack: 1'b0, as_off: 8'd20, exp_low: 1'b1},
      '{ack: 1'b1, as_off: 8'd20, exp_low: 1'b0},
      '{ack: 1'b0, as_off: 8'd2,  exp_low: 1'b0},
      '{ack: 1'b0, as_off: 8'd4,  exp_low: 1'b0},
      '{ack: 1'b0, as_off: 8'd5,  exp_low: 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ack_n = 1'b1, as_n = 1'b1, dsa_n = 1'b1;
   logic out_n;
   int   n_cmp = 0, n_mis = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   iack_chain_origin #(.SYNC_STAGES(SYNC), .ASSERT_DLY(DLY), .RELEASE_MAX(REL),
                       .RECOVER_CYC(REC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_ack_n(ack_n), .addr_strobe_n(as_n),
      .data_strobe_a_n(dsa_n), .chain_out_n(out_n));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_mis++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // watch out_n for n cycles, return number of low samples
   task automatic count_low(input int n, output int lows);
      lows = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
         if (!out_n) lows++;
      end
   endtask

   task automatic wait_level(input logic lvl, output int n);
      n = 0;
      for (int i = 1; i <= WIN; i++) begin
         @(posedge clk); @(negedge clk);
         if (out_n == lvl) begin n = i; break; end
      end
   endtask

   task automatic cleanup();
      dsa_n = 1'b1; as_n = 1'b1; ack_n = 1'b1;
      idle(REC + DLY + 12);
   endtask

   initial begin
      int first_low, last_low, lows, n;
      bit exp_calc;
      idle(3);
      chk(out_n == 1'b1, "R1 reset", out_n, 1);
      rst_n = 1'b1;
      idle(4);
      chk(out_n == 1'b1, "R1 idle", out_n, 1);

      // table walk: R2 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         exp_calc = (VEC[v].ack == 1'b0) && (int'(VEC[v].as_off) > DLY);
         chk(exp_calc == VEC[v].exp_low, "R6 table", VEC[v].exp_low, exp_calc);
         ack_n = VEC[v].ack; as_n = 1'b0; dsa_n = 1'b1;
         idle(8);
         first_low = 0; last_low = 0; lows = 0;
         dsa_n = 1'b0;
         if (VEC[v].as_off == 0) as_n = 1'b1;
         for (int i = 1; i <= WIN; i++) begin
            @(posedge clk); @(negedge clk);
            if (!out_n) begin
               lows++;
               if (first_low == 0) first_low = i;
               last_low = i;
            end
            if (i == int'(VEC[v].as_off)) as_n = 1'b1;
         end
         if (VEC[v].exp_low) begin
            chk(first_low == LAT, "R4 latency", first_low, LAT);
            chk(last_low == int'(VEC[v].as_off) + SYNC, "R5 release", last_low,
                int'(VEC[v].as_off) + SYNC);
            chk(last_low - first_low + 1 <= REL + 40, "R5 bound", last_low, first_low);
            chk(lows == last_low - first_low + 1, "R9 held low", lows,
                last_low - first_low + 1);
         end else begin
            chk(lows == 0, (VEC[v].ack ? "R2 no ack" : "R6 cancel"), lows, 0);
         end
         cleanup();
      end

      // R3: ack falls while data strobe already low
      ack_n = 1'b1; as_n = 1'b0; dsa_n = 1'b0;
      idle(10);
      ack_n = 1'b0;
      count_low(25, lows);
      chk(lows == 0, "R3 level not edge", lows, 0);
      cleanup();

      // R7 / R8: edge inside recovery window is dropped, later edge works
      ack_n = 1'b0; as_n = 1'b0; dsa_n = 1'b1;
      idle(8);
      dsa_n = 1'b0;
      wait_level(1'b0, n);
      chk(n == LAT, "R4 latency directed", n, LAT);
      as_n = 1'b1;
      wait_level(1'b1, n);
      chk(n == SYNC + 1, "R5 release directed", n, SYNC + 1);
      as_n = 1'b0; dsa_n = 1'b1;
      @(negedge clk);
      dsa_n = 1'b0;
      count_low(30, lows);
      chk(lows == 0, "R7 edge in recovery ignored", lows, 0);
      dsa_n = 1'b1;
      idle(4);
      dsa_n = 1'b0;
      wait_level(1'b0, n);
      chk(n == LAT, "R8 reassert after recovery", n, LAT);
      as_n = 1'b1;
      wait_level(1'b1, n);
      chk(n == SYNC + 1, "R5 second release", n, SYNC + 1);
      cleanup();
      chk(out_n == 1'b1, "R1 final idle", out_n, 1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_mis++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end
endmodule